// File: doc/BRIEF.md
# Real-Time Clock Register Port

This block is the host-facing register side of a real-time clock. Software reaches every register through two byte-wide ports. It first writes a register number to the index port. It then reads or writes the data port, which acts on the register that was selected. Ten clock/calendar bytes sit at the low register numbers. Above them are two status registers: the first holds the oscillator divider and rate settings, the second holds the format and interrupt-enable settings. The two registers after those are decoded but not built, so any access to them is flagged. The block does not advance the time; it only stores and returns the bytes.

Requests arrive on a valid/ready channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Only reads produce a response, which goes out on a second valid/ready channel. A read response stays on `rsp_rdata`, unchanged, until the consumer raises `rsp_ready`. While a response waits, `req_ready` stays low, so back-pressure on the response side stalls the request side. Writes complete on the cycle they are taken.

A periodic interrupt generator is gated by the enable bit of the second status register. While that bit is set, it emits a one-cycle pulse at a fixed interval of system clock cycles and then rearms itself. A sticky error flag reports any request the register file refuses.

Top module: `rtc_regif`

## Requirements
- R1: An index-port write of a value 0x00..0x0D selects that register number. A larger value sets the error flag and leaves the selection unchanged. An index-port read returns the current selection.
- R2: Register numbers 0x00..0x09 are plain byte storage, written and read back through the data port. After reset they read 0x00, except number 0x06, the weekday byte, which reads 0x01 (Sunday, with the weekday counted from one).
- R3: Status register A (number 0x0A) resets to 0x26. Bits 6:4 = 010 select the 32.768 kHz base and bits 3:0 = 0110 select the 1024 Hz rate. A write of any value other than 0x26 sets the error flag. No data-port write changes register A.
- R4: Each data-port read of register A inverts its bit 7 (update in progress) and returns the inverted value. The first read after reset returns 0xA6 and the second returns 0x26.
- R5: Status register B (number 0x0B) resets to 0x46: bit 6 periodic enable = 1, bit 3 square-wave enable = 0, bit 2 binary format = 1, bit 1 24-hour mode = 1.
- R6: A write to register B is stored only if (data & 0xB7) == 0x06. Any other write sets the error flag and leaves register B unchanged.
- R7: While the periodic enable is set, `irq_pulse` is high for exactly one cycle in every PERIOD_CYC cycles.
- R8: The periodic generator follows the enable bit one cycle later. Setting the bit while the generator is stopped starts a new interval from zero. Writing the bit as 1 while the generator runs does not restart it. Clearing the bit stops the generator, and no pulse follows.
- R9: Any data-port read or write of register numbers 0x0C or 0x0D sets the error flag. Such reads return 0x00.
- R10: The error flag stays set until reset.
- R11: `req_ready` is low while a read response is pending. A pending response holds `rsp_valid` and `rsp_rdata` stable until `rsp_ready`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_port | input | 1 | 0 = index port, 1 = data port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 8 | Read response data |
| irq_pulse | output | 1 | One-cycle periodic interrupt |
| err_flag | output | 1 | Sticky error flag |

## Verification
The handshake assertions assume that the consumer obeys valid/ready. They also assume that request fields are defined whenever `req_valid` is high. The bench drives every input only on falling edges and keeps request fields fixed until the request is taken. The pulse-spacing assertions assume a PERIOD_CYC of at least two, and the bench uses a short interval so that many periods fit in the run. Error cases are each followed by a reset, so the sticky flag from one case never hides the next.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned N_TIME = 10;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam idx_t IDX_STAT_A = 4'hA;
  localparam idx_t IDX_STAT_B = 4'hB;
  localparam idx_t IDX_STAT_C = 4'hC;
  localparam idx_t IDX_LAST   = 4'hD;

  localparam byte_t UIP_BIT   = 8'h80;
  localparam byte_t STATA_RST = 8'h26;
  localparam byte_t PIE_BIT   = 8'h40;
  localparam byte_t SQW_BIT   = 8'h08;
  localparam byte_t BIN_BIT   = 8'h04;
  localparam byte_t H24_BIT   = 8'h02;
  localparam byte_t STATB_RST = PIE_BIT | BIN_BIT | H24_BIT;

  typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} port_e;

  typedef struct packed {
    port_e port;
    logic  wr;
    byte_t data;
  } acc_t;

  function automatic logic statb_ok(byte_t v);
    return (v & ~(PIE_BIT | SQW_BIT)) == (BIN_BIT | H24_BIT);
  endfunction

endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_regif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  output logic  req_ready,
  input  logic  req_port,
  input  logic  req_write,
  input  byte_t req_wdata,
  output logic  rsp_valid,
  input  logic  rsp_ready,
  output byte_t rsp_rdata,
  output logic  acc_fire,
  output acc_t  acc,
  input  byte_t rd_value
);

  logic  rsp_valid_q;
  byte_t rsp_data_q;

  assign req_ready = !rsp_valid_q;
  assign acc_fire  = req_valid && req_ready;
  assign acc.port  = port_e'(req_port);
  assign acc.wr    = req_write;
  assign acc.data  = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      if (acc_fire && !req_write) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_value;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  // R11: a stalled response keeps its data
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R11: no request is taken while a response waits
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R11: a write never creates a response
  p_wr_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && req_write |=> !rsp_valid);

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regif_pkg::*;
#(
  parameter int unsigned WDAY_IDX = 6,
  parameter int unsigned WDAY_RST = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  acc_fire,
  input  acc_t  acc,
  output byte_t rd_value,
  output logic  pie_en,
  output logic  err_flag
);

  idx_t  idx_q;
  byte_t stata_q;
  byte_t statb_q;
  logic  err_q;
  byte_t time_rd [N_TIME];
  byte_t rd_time;

  logic on_index, on_data, is_time, is_a, is_b, is_cd;
  logic idx_wr, time_wr, a_rd, a_wr, b_wr, cd_acc, idx_bad, a_bad, b_bad;

  always_comb begin
    on_index = acc_fire && (acc.port == PORT_INDEX);
    on_data  = acc_fire && (acc.port == PORT_DATA);
    is_time  = idx_q < IDX_STAT_A;
    is_a     = idx_q == IDX_STAT_A;
    is_b     = idx_q == IDX_STAT_B;
    is_cd    = idx_q >= IDX_STAT_C;
    idx_wr   = on_index && acc.wr;
    time_wr  = on_data && acc.wr && is_time;
    a_rd     = on_data && !acc.wr && is_a;
    a_wr     = on_data && acc.wr && is_a;
    b_wr     = on_data && acc.wr && is_b;
    cd_acc   = on_data && is_cd;
    idx_bad  = idx_wr && (acc.data > byte_t'(IDX_LAST));
    a_bad    = a_wr && (acc.data != STATA_RST);
    b_bad    = b_wr && !statb_ok(acc.data);
  end

  for (genvar g = 0; g < N_TIME; g++) begin : g_time
    localparam byte_t RST_VAL = (g == WDAY_IDX) ? byte_t'(WDAY_RST) : byte_t'(0);
    byte_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                q <= RST_VAL;
      else if (time_wr && idx_q == idx_t'(g))    q <= acc.data;
    end
    assign time_rd[g] = q;
  end

  always_comb begin
    rd_time = '0;
    for (int i = 0; i < N_TIME; i++)
      if (idx_q == idx_t'(i)) rd_time = time_rd[i];
  end

  always_comb begin
    if (acc.port == PORT_INDEX) rd_value = byte_t'(idx_q);
    else if (is_time)           rd_value = rd_time;
    else if (is_a)              rd_value = stata_q ^ UIP_BIT;
    else if (is_b)              rd_value = statb_q;
    else                        rd_value = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      stata_q <= STATA_RST;
      statb_q <= STATB_RST;
      err_q   <= 1'b0;
    end else begin
      if (idx_wr && !idx_bad)  idx_q   <= idx_t'(acc.data);
      if (a_rd)                stata_q <= stata_q ^ UIP_BIT;
      if (b_wr && !b_bad)      statb_q <= acc.data;
      if (idx_bad || a_bad || b_bad || cd_acc) err_q <= 1'b1;
    end
  end

  assign pie_en   = (statb_q & PIE_BIT) != '0;
  assign err_flag = err_q;

  // R1: the selection never leaves the decoded range
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_LAST);
  // R1: an out-of-range index is flagged
  p_idx_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr && acc.data > byte_t'(IDX_LAST) |=> err_q);
  // R3: a foreign value written to A is flagged
  p_stata_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr && acc.data != STATA_RST |=> err_q);
  // R4: every read of A flips the update bit
  p_uip_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd |=> stata_q[7] != $past(stata_q[7]));
  // R6: B always holds a legal pattern
  p_statb_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    statb_ok(statb_q));
  // R9: C/D accesses are flagged
  p_cd_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cd_acc |=> err_q);
  // R10: the flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int unsigned PERIOD_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic irq_pulse
);

  localparam int unsigned CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign irq_pulse = run_q && (cnt_q == LAST);

  // R7: the pulse lasts one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R8: a disabled generator is silent on the next cycle
  p_irq_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_pulse);

endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_regif_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 32,
  parameter int unsigned WDAY_IDX   = 6,
  parameter int unsigned WDAY_RST   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_port,
  input  logic       req_write,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_rdata,
  output logic       irq_pulse,
  output logic       err_flag
);

  logic  acc_fire;
  acc_t  acc;
  byte_t rd_value;
  logic  pie_en;

  rtc_host_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_port  (req_port),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .acc_fire  (acc_fire),
    .acc       (acc),
    .rd_value  (rd_value)
  );

  rtc_regfile #(
    .WDAY_IDX (WDAY_IDX),
    .WDAY_RST (WDAY_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_fire (acc_fire),
    .acc      (acc),
    .rd_value (rd_value),
    .pie_en   (pie_en),
    .err_flag (err_flag)
  );

  rtc_periodic #(
    .PERIOD_CYC (PERIOD_CYC)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (pie_en),
    .irq_pulse (irq_pulse)
  );

endmodule

// File: tb/tb_rtc_regif.sv
module tb_rtc_regif;

  localparam int CLK_NS = 10;
  localparam int PER    = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_port = 1'b0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic       irq_pulse;
  logic       err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_NS/2) clk = ~clk;

  rtc_regif #(.PERIOD_CYC(PER)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_pulse(irq_pulse), .err_flag(err_flag)
  );

  // behavioural reference
  int       m_idx, m_cnt;
  bit [7:0] m_tb [10];
  bit [7:0] m_ra, m_rb, m_rd;
  bit       m_run, m_err, m_rv;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; foreach (m_tb[i]) m_tb[i] = 8'h00; m_tb[6] = 8'h01;
      m_ra = 8'h26; m_rb = 8'h46; m_run = 0; m_cnt = 0; m_err = 0;
      m_rv = 0; m_rd = 0;
    end else begin
      bit acc;
      acc = req_valid && !m_rv;
      if (!m_rb[6]) begin m_run = 0; m_cnt = 0; end
      else if (!m_run) begin m_run = 1; m_cnt = 0; end
      else m_cnt = (m_cnt == PER-1) ? 0 : m_cnt + 1;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin
        if (!req_port) begin
          if (req_write) begin
            if (req_wdata <= 8'h0D) m_idx = req_wdata; else m_err = 1;
          end else begin m_rv = 1; m_rd = 8'(m_idx); end
        end else if (req_write) begin
          if (m_idx < 10) m_tb[m_idx] = req_wdata;
          else if (m_idx == 10) begin if (req_wdata != 8'h26) m_err = 1; end
          else if (m_idx == 11) begin
            if ((req_wdata & 8'hB7) == 8'h06) m_rb = req_wdata; else m_err = 1;
          end else m_err = 1;
        end else begin
          m_rv = 1;
          if (m_idx < 10) m_rd = m_tb[m_idx];
          else if (m_idx == 10) begin m_ra = m_ra ^ 8'h80; m_rd = m_ra; end
          else if (m_idx == 11) m_rd = m_rb;
          else begin m_rd = 8'h00; m_err = 1; end
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 req_ready", req_ready, !m_rv);
      chk("R11 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk("R11 rsp_rdata", rsp_rdata, m_rd);
      chk("R7 irq_pulse", irq_pulse, (m_run && m_cnt == PER-1));
      chk("R10 err_flag", err_flag, m_err);
    end
  end

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic xfer(bit prt, bit wr, logic [7:0] d);
    bit took;
    @(negedge clk);
    req_valid = 1; req_port = prt; req_write = wr; req_wdata = d;
    forever begin
      took = req_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(bit prt, string tag, logic [7:0] exp);
    xfer(prt, 0, 8'h00);
    while (!rsp_valid) @(negedge clk);
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic sel(logic [7:0] i);
    xfer(0, 1, i);
  endtask

  initial begin
    int pulses;
    do_reset();
    @(negedge clk);
    chk("R11 reset rsp_valid", rsp_valid, 0);
    chk("R10 reset err", err_flag, 0);
    chk("R7 reset irq", irq_pulse, 0);

    sel(8'h0A);
    rd(1, "R4 first A read", 8'hA6);
    rd(1, "R4 second A read", 8'h26);
    rd(1, "R3 A reset value", 8'hA6);
    sel(8'h0B);
    rd(1, "R5 B reset value", 8'h46);
    sel(8'h06);
    rd(1, "R2 weekday reset", 8'h01);
    sel(8'h00);
    rd(1, "R2 byte0 reset", 8'h00);

    for (int i = 0; i < 10; i++) begin
      sel(8'(i)); xfer(1, 1, 8'(8'h13 + 7*i));
    end
    for (int i = 9; i >= 0; i--) begin
      sel(8'(i));
      rd(0, "R1 index readback", 8'(i));
      rd(1, "R2 time byte readback", 8'(8'h13 + 7*i));
    end

    sel(8'h0A); xfer(1, 1, 8'h26);
    chk("R3 legal A write", err_flag, 0);
    sel(8'h0B); xfer(1, 1, 8'h4E);
    rd(1, "R6 B square-wave write", 8'h4E);
    chk("R6 legal B write", err_flag, 0);

    // back-pressure on the response
    @(negedge clk); rsp_ready = 0;
    sel(8'h03);
    xfer(1, 0, 8'h00);
    repeat (5) begin
      @(negedge clk);
      chk("R11 held valid", rsp_valid, 1);
      chk("R11 held ready", req_ready, 0);
    end
    chk("R11 held data", rsp_rdata, 8'(8'h13 + 21));
    rsp_ready = 1;

    // periodic enable off, then on
    sel(8'h0B); xfer(1, 1, 8'h06);
    pulses = 0;
    repeat (3*PER) begin @(negedge clk); pulses += irq_pulse; end
    chk("R8 no pulse when disabled", pulses, 0);
    xfer(1, 1, 8'h46);
    pulses = 0;
    repeat (4*PER) begin @(negedge clk); pulses += irq_pulse; end
    chk("R7 pulses in four periods", pulses, 4);
    repeat (5) @(negedge clk);
    xfer(1, 1, 8'h46);
    repeat (2*PER) @(negedge clk);

    // error cases
    sel(8'h05); sel(8'h0E);
    chk("R1 bad index err", err_flag, 1);
    rd(0, "R1 index kept", 8'h05);
    do_reset();
    sel(8'h0A); xfer(1, 1, 8'h27);
    chk("R3 bad A err", err_flag, 1);
    rd(1, "R3 A unchanged", 8'hA6);
    do_reset();
    sel(8'h0B); xfer(1, 1, 8'h40);
    chk("R6 bad B err", err_flag, 1);
    rd(1, "R6 B unchanged", 8'h46);
    do_reset();
    sel(8'h0C); xfer(1, 1, 8'h00);
    chk("R9 C write err", err_flag, 1);
    do_reset();
    sel(8'h0D);
    rd(1, "R9 D read data", 8'h00);
    @(negedge clk);
    chk("R9 D read err", err_flag, 1);
    repeat (10) @(negedge clk);
    chk("R10 err still set", err_flag, 1);

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule